// File: doc/BRIEF.md
# 1-Wire Bus Master Engine

The engine drives one open-drain 1-Wire line for a host that talks to four small registers. A programmable divisor turns the system clock into a 1 us tick. Every bus timing is counted in these ticks. Setting a control bit produces a bus reset pulse and records whether a device answered with a presence pulse. A write to the data register runs a burst of time slots. In every slot the engine transmits a bit and also samples the line, so the bits sampled back replace the data register contents. To read, the host writes ones.

Three transfer modes are available. Byte mode runs eight slots, least significant bit first. Single-bit mode runs one slot on bit 0. Search mode turns the low nibble of the written byte into four direction bits. For each direction bit the engine runs a read/read/write triplet, which is the step a device-tree search needs. The engine hands back four discrepancy flags and the four bits it chose. An overdrive bit shortens every timing. Four sticky flags report progress and line faults: reset done, transmit empty, receive ready and line short.

Top module: `onewire_master`

Register map (reg_addr_i): 0 = DATA, 1 = CTRL, 2 = FLAGS, 3 = DIV. CTRL bits: 0 start reset (write-only pulse, reads 0), 1 single-bit mode, 2 overdrive, 3 search mode, 4 pull-up enable, 5 presence (read-only), 6 busy (read-only). FLAGS bits: 0 reset done, 1 transmit empty, 2 receive ready, 3 line short.

## Requirements
- R1: After rst_ni is released, DATA, CTRL and FLAGS read 0x00, DIV reads DIV_RESET (8), and line_drive_o and pullup_en_o are 0.
- R2: DIV holds the number of system clocks per 1 us tick. A write of 0 to DIV is ignored and the previous value is kept. All bus timings scale with DIV.
- R3: Writing 1 to CTRL bit 0 while idle produces a reset pulse that holds the line low for 480 us at standard speed. When the sequence ends, FLAGS bit 0 is set and CTRL bit 5 reads 1 if the line was low 70 us after release, and 0 if it was high.
- R4: With CTRL bit 2 set, timings become overdrive: reset low 70 us, presence sampled 9 us after release, write-0 low 8 us, write-1/read low 1 us, sample at 2 us, slot 10 us.
- R5: In byte mode (CTRL bits 1 and 3 clear), a DATA write runs 8 slots, LSB first. The 8 sampled bits replace DATA, so writing 0xFF with a device returning 0xA5 reads back 0xA5, and writing 0x3C to an idle bus reads back 0x3C.
- R6: In single-bit mode (CTRL bit 1 set, bit 3 clear), a DATA write runs exactly one slot that sends DATA bit 0. DATA then becomes {7'b0, sampled bit}.
- R7: FLAGS bit 1 (transmit empty) is set when the last slot of a DATA transfer starts. FLAGS bit 2 (receive ready) is set later, when the sampled result is in DATA.
- R8: Writing 1 to a FLAGS bit clears it. Writing 0 leaves it unchanged.
- R9: FLAGS bit 3 (line short) is set if the synchronized line is low when a reset or data transfer starts.
- R10: In search mode (CTRL bit 3 set; this overrides bit 1), a DATA write runs four triplets of 12 slots in total. For triplet j the engine reads bit a, then bit b, then writes a bit. If a and b are both 0, it writes direction bit j (DATA bit j) and sets discrepancy j. Otherwise it writes a. DATA becomes {written[3:0], discrepancy[3:0]}.
- R11: DATA writes and start-reset requests that arrive while a transfer is running are ignored.
- R12: At standard speed, a write-0 slot holds the line low for 60 us and a write-1 or read slot for 6 us. The line is sampled 15 us into the slot, and each slot lasts 70 us.
- R13: pullup_en_o follows CTRL bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from reg_addr_i) |
| line_i | input | 1 | Sensed level of the 1-Wire line |
| line_drive_o | output | 1 | 1 pulls the line low (open-drain enable) |
| pullup_en_o | output | 1 | Pull-up enable |

## Verification
The hardest case to reach is search mode. Its written bits depend on what the line returned in the two read slots just before. The bench therefore models a bus device that, on each falling edge driven by the engine, holds the line low or releases it according to a preloaded per-slot bit stream. This produces all three triplet outcomes (conflict, all-ones and all-zeros) within one transfer, and the stream also supplies the read data and presence answers. Slot and reset low times are measured in clock cycles at the line_drive_o port and compared with the microsecond figures at both speeds.

// File: rtl/onewire_pkg.sv
package onewire_pkg;
  localparam int unsigned TCNT_W = 10;

  typedef enum logic [1:0] {
    XFER_BYTE   = 2'd0,
    XFER_BIT    = 2'd1,
    XFER_SEARCH = 2'd2
  } xfer_mode_e;

  typedef struct packed {
    logic [TCNT_W-1:0] low;   // ticks driven low
    logic [TCNT_W-1:0] smp;   // tick at which line is sampled
    logic [TCNT_W-1:0] last;  // final tick of slot
  } slot_time_t;

  // Timings in 1 us ticks; overdrive fractions rounded up
  function automatic slot_time_t slot_time(input logic is_rst, input logic od, input logic wbit);
    slot_time_t t;
    unique case ({is_rst, od})
      2'b10: t = '{low: 10'd480, smp: 10'd550, last: 10'd959};
      2'b11: t = '{low: 10'd70,  smp: 10'd79,  last: 10'd159};
      2'b00: t = '{low: wbit ? 10'd6 : 10'd60, smp: 10'd15, last: 10'd69};
      default: t = '{low: wbit ? 10'd1 : 10'd8, smp: 10'd2, last: 10'd9};
    endcase
    return t;
  endfunction
endpackage

// File: rtl/onewire_tick.sv
module onewire_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/onewire_slot.sv
module onewire_slot
  import onewire_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic is_rst_i,
  input  logic wbit_i,
  input  logic od_i,
  input  logic line_i,
  output logic drive_o,
  output logic done_o,
  output logic sample_o
);
  logic              busy_q, rst_q, od_q, wbit_q;
  logic [TCNT_W-1:0] cnt_q;
  slot_time_t        tm;

  assign tm      = slot_time(rst_q, od_q, wbit_q);
  assign drive_o = busy_q && (cnt_q < tm.low);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      rst_q    <= 1'b0;
      od_q     <= 1'b0;
      wbit_q   <= 1'b1;
      cnt_q    <= '0;
      done_o   <= 1'b0;
      sample_o <= 1'b1;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        rst_q  <= is_rst_i;
        od_q   <= od_i;
        wbit_q <= wbit_i;
      end else if (busy_q && tick_i) begin
        if (cnt_q == tm.smp) sample_o <= line_i;
        if (cnt_q == tm.last) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/onewire_seq.sv
module onewire_seq
  import onewire_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_rst_i,
  input  logic       go_data_i,
  input  xfer_mode_e mode_i,
  input  logic [7:0] data_i,
  input  logic       slot_done_i,
  input  logic       slot_sample_i,
  output logic       slot_start_o,
  output logic       slot_is_rst_o,
  output logic       slot_wbit_o,
  output logic       busy_o,
  output logic       last_launch_o,
  output logic       done_data_o,
  output logic       done_rst_o,
  output logic [7:0] result_o
);
  localparam logic [3:0] LAST_BYTE   = 4'd7;
  localparam logic [3:0] LAST_SEARCH = 4'd11;

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT} st_e;

  st_e        st_q;
  xfer_mode_e mode_q;
  logic       is_rst_q, a_q, b_q, last_slot;
  logic [7:0] tx_q, rx_q;
  logic [3:0] idx_q, disc_q, wr_q;
  logic [1:0] ph_q, trip_q;

  always_comb begin
    unique case (mode_q)
      XFER_BYTE:   last_slot = (idx_q == LAST_BYTE);
      XFER_SEARCH: last_slot = (idx_q == LAST_SEARCH);
      default:     last_slot = 1'b1;
    endcase
  end

  always_comb begin
    if (is_rst_q) slot_wbit_o = 1'b1;
    else begin
      unique case (mode_q)
        XFER_BYTE:   slot_wbit_o = tx_q[idx_q[2:0]];
        XFER_SEARCH: slot_wbit_o = (ph_q != 2'd2) ? 1'b1 : ((a_q | b_q) ? a_q : tx_q[trip_q]);
        default:     slot_wbit_o = tx_q[0];
      endcase
    end
  end

  assign slot_start_o  = (st_q == S_LAUNCH);
  assign slot_is_rst_o = is_rst_q;
  assign busy_o        = (st_q != S_IDLE);
  assign last_launch_o = slot_start_o && !is_rst_q && last_slot;
  assign result_o      = (mode_q == XFER_SEARCH) ? {wr_q, disc_q} : rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      mode_q      <= XFER_BYTE;
      is_rst_q    <= 1'b0;
      tx_q        <= '0;
      rx_q        <= '0;
      idx_q       <= '0;
      ph_q        <= '0;
      trip_q      <= '0;
      a_q         <= 1'b0;
      b_q         <= 1'b0;
      disc_q      <= '0;
      wr_q        <= '0;
      done_data_o <= 1'b0;
      done_rst_o  <= 1'b0;
    end else begin
      done_data_o <= 1'b0;
      done_rst_o  <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (go_rst_i) begin
            is_rst_q <= 1'b1;
            st_q     <= S_LAUNCH;
          end else if (go_data_i) begin
            is_rst_q <= 1'b0;
            mode_q   <= mode_i;
            tx_q     <= data_i;
            rx_q     <= '0;
            idx_q    <= '0;
            ph_q     <= '0;
            trip_q   <= '0;
            disc_q   <= '0;
            wr_q     <= '0;
            st_q     <= S_LAUNCH;
          end
        end
        S_LAUNCH: st_q <= S_WAIT;
        default: begin
          if (slot_done_i) begin
            if (is_rst_q) begin
              done_rst_o <= 1'b1;
              st_q       <= S_IDLE;
            end else begin
              unique case (mode_q)
                XFER_BYTE: rx_q[idx_q[2:0]] <= slot_sample_i;
                XFER_SEARCH: begin
                  if (ph_q == 2'd0) a_q <= slot_sample_i;
                  else if (ph_q == 2'd1) b_q <= slot_sample_i;
                  else begin
                    wr_q[trip_q]   <= slot_wbit_o;
                    disc_q[trip_q] <= ~a_q & ~b_q;
                  end
                end
                default: rx_q <= {7'b0, slot_sample_i};
              endcase
              if (last_slot) begin
                done_data_o <= 1'b1;
                st_q        <= S_IDLE;
              end else begin
                idx_q <= idx_q + 1'b1;
                if (ph_q == 2'd2) begin
                  ph_q   <= '0;
                  trip_q <= trip_q + 1'b1;
                end else begin
                  ph_q <= ph_q + 1'b1;
                end
                st_q <= S_LAUNCH;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import onewire_pkg::*;
#(
  parameter int unsigned       DIV_W     = 8,
  parameter logic [DIV_W-1:0]  DIV_RESET = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       line_i,
  output logic       line_drive_o,
  output logic       pullup_en_o
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_FLAG = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;
  localparam int unsigned NFLAG = 4;

  logic [7:0]       data_q;
  logic [DIV_W-1:0] div_q;
  logic [NFLAG-1:0] flags_q, flag_set;
  logic             single_q, od_q, search_q, pu_q, pres_q;
  logic             sync1_q, line_s;
  logic             wr_data, wr_ctrl, wr_flag, wr_div, go_rst, go_data;
  logic             tick, slot_start, slot_is_rst, slot_wbit, slot_done, slot_sample;
  logic             seq_busy, last_launch, done_data, done_rst;
  logic [7:0]       seq_result;
  xfer_mode_e       mode;

  assign wr_data = reg_we_i && (reg_addr_i == A_DATA);
  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_flag = reg_we_i && (reg_addr_i == A_FLAG);
  assign wr_div  = reg_we_i && (reg_addr_i == A_DIV);
  assign go_rst  = wr_ctrl && reg_wdata_i[0] && !seq_busy;
  assign go_data = wr_data && !seq_busy;
  assign mode    = search_q ? XFER_SEARCH : (single_q ? XFER_BIT : XFER_BYTE);

  assign flag_set = {(go_rst || go_data) && !line_s, done_data, last_launch, done_rst};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      line_s  <= 1'b1;
    end else begin
      sync1_q <= line_i;
      line_s  <= sync1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      div_q    <= DIV_RESET;
      flags_q  <= '0;
      single_q <= 1'b0;
      od_q     <= 1'b0;
      search_q <= 1'b0;
      pu_q     <= 1'b0;
      pres_q   <= 1'b0;
    end else begin
      if (done_data)    data_q <= seq_result;
      else if (go_data) data_q <= reg_wdata_i;
      if (wr_div && (reg_wdata_i[DIV_W-1:0] != '0)) div_q <= reg_wdata_i[DIV_W-1:0];
      if (wr_ctrl) begin
        single_q <= reg_wdata_i[1];
        od_q     <= reg_wdata_i[2];
        search_q <= reg_wdata_i[3];
        pu_q     <= reg_wdata_i[4];
      end
      if (done_rst) pres_q <= ~slot_sample;
      flags_q <= (flags_q & ~({NFLAG{wr_flag}} & reg_wdata_i[NFLAG-1:0])) | flag_set;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_DATA:  reg_rdata_o = data_q;
      A_CTRL:  reg_rdata_o = {1'b0, seq_busy, pres_q, pu_q, search_q, od_q, single_q, 1'b0};
      A_FLAG:  reg_rdata_o = {{(8-NFLAG){1'b0}}, flags_q};
      default: reg_rdata_o = 8'(div_q);
    endcase
  end

  assign pullup_en_o = pu_q;

  onewire_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_q),
    .tick_o (tick)
  );

  onewire_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .go_rst_i      (go_rst),
    .go_data_i     (go_data),
    .mode_i        (mode),
    .data_i        (reg_wdata_i),
    .slot_done_i   (slot_done),
    .slot_sample_i (slot_sample),
    .slot_start_o  (slot_start),
    .slot_is_rst_o (slot_is_rst),
    .slot_wbit_o   (slot_wbit),
    .busy_o        (seq_busy),
    .last_launch_o (last_launch),
    .done_data_o   (done_data),
    .done_rst_o    (done_rst),
    .result_o      (seq_result)
  );

  onewire_slot u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .start_i  (slot_start),
    .is_rst_i (slot_is_rst),
    .wbit_i   (slot_wbit),
    .od_i     (od_q),
    .line_i   (line_s),
    .drive_o  (line_drive_o),
    .done_o   (slot_done),
    .sample_o (slot_sample)
  );
endmodule

// File: rtl/onewire_master_chk.sv
module onewire_master_chk #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             drive_i,
  input logic             done_data_i,
  input logic             wr_data_i,
  input logic [7:0]       data_i,
  input logic [DIV_W-1:0] div_i,
  input logic [3:0]       flags_i
);
  // R12
  idle_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !drive_i);

  // R11
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_data_i && !done_data_i) |=> $stable(data_i));

  // R7
  rx_after_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[2]) |-> $past(busy_i, 2));

  // R3
  rst_done_after_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[0]) |-> $past(busy_i, 2));

  // R2
  div_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_i != '0);
endmodule

bind onewire_master onewire_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (seq_busy),
  .drive_i     (line_drive_o),
  .done_data_i (done_data),
  .wr_data_i   (wr_data),
  .data_i      (data_q),
  .div_i       (div_q),
  .flags_i     (flags_q)
);

// File: tb/sim_onewire_master.sv
module sim_onewire_master;
  localparam int D = 4;          // divisor used by the bench
  localparam int RST_THR = 65 * D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       drv, pu, line;

  logic        stuck = 1'b0, pres_en = 1'b0, dev_od = 1'b0;
  logic [15:0] dev_bits = '0;
  int          dev_n = 0, dev_gen = 0;
  int          seen_gen = 0, ptr = 0, hold = 0, pwait = 0, plow = 0;
  int          low_len = 0, last_low = 0, fall_cnt = 0;
  logic        drv_d = 1'b0;
  int          n_chk = 0, n_bad = 0, last_falls = 0;

  always #4 clk = ~clk;

  assign line = !(drv || (hold > 0) || (plow > 0) || stuck);

  onewire_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .line_i(line),
    .line_drive_o(drv), .pullup_en_o(pu)
  );

  // bus device model
  always @(posedge clk) begin
    drv_d <= drv;
    if (drv) low_len <= low_len + 1;
    else     low_len <= 0;
    if (dev_gen != seen_gen) begin
      seen_gen <= dev_gen;
      ptr <= 0;
    end else if (drv && !drv_d) begin
      fall_cnt <= fall_cnt + 1;
      if (ptr < dev_n) begin
        if (!dev_bits[ptr]) hold <= dev_od ? 5 * D : 40 * D;
        ptr <= ptr + 1;
      end
    end else if (hold > 0) hold <= hold - 1;
    if (!drv && drv_d) begin
      last_low <= low_len;
      if (pres_en && low_len >= RST_THR) pwait <= dev_od ? 2 * D : 30 * D;
    end else if (pwait > 0) begin
      pwait <= pwait - 1;
      if (pwait == 1) plow <= dev_od ? 15 * D : 240 * D;
    end else if (plow > 0) plow <= plow - 1;
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic chk_rng(input string r, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d..%0d", r, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_flag(input int b);
    logic [7:0] f;
    do rd(2'd2, f); while (!f[b]);
  endtask

  task automatic load_dev(input logic [15:0] bits, input int n, input logic od);
    @(negedge clk);
    dev_bits = bits; dev_n = n; dev_od = od; dev_gen = dev_gen + 1;
    @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] res);
    int f0;
    f0 = fall_cnt;
    wr(2'd0, d);
    wait_flag(2);
    rd(2'd0, res);
    last_falls = fall_cnt - f0;
    wr(2'd2, 8'h0F);
  endtask

  task automatic t_reset_state;
    logic [7:0] v;
    rd(2'd0, v); chk("R1 data", int'(v), 0);
    rd(2'd1, v); chk("R1 ctrl", int'(v), 0);
    rd(2'd2, v); chk("R1 flags", int'(v), 0);
    rd(2'd3, v); chk("R1 div", int'(v), 8);
    chk("R1 drive", int'(drv), 0);
    chk("R1 pullup", int'(pu), 0);
  endtask

  task automatic t_div;
    logic [7:0] v;
    wr(2'd3, 8'(D));
    rd(2'd3, v); chk("R2 div write", int'(v), D);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R2 div zero ignored", int'(v), D);
  endtask

  task automatic t_reset_pulse(input logic od, input logic pres, input int low_us);
    logic [7:0] v;
    load_dev('0, 0, od);
    pres_en = pres;
    wr(2'd1, {5'b0, od, 2'b01});
    wait_flag(0);
    chk_rng(od ? "R4 reset low" : "R3 reset low (R2 scale)", last_low, low_us * D - D, low_us * D + 1);
    rd(2'd1, v);
    chk(od ? "R4 presence" : "R3 presence", int'(v[5]), int'(pres));
    rd(2'd2, v); chk("R3 only reset_done", int'(v), 1);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R8 clear reset_done", int'(v), 0);
    pres_en = 1'b0;
  endtask

  task automatic t_byte;
    logic [7:0] v;
    int f0;
    load_dev('0, 0, 1'b0);
    wr(2'd1, 8'h00);
    f0 = fall_cnt;
    wr(2'd0, 8'h3C);
    wait_flag(1);
    rd(2'd2, v); chk("R7 rx not before tx", int'(v[2]), 0);
    wait_flag(2);
    rd(2'd0, v); chk("R5 write echo", int'(v), 8'h3C);
    chk("R5 eight slots", fall_cnt - f0, 8);
    rd(2'd2, v); chk("R7 both flags", int'(v), 8'h06);
    wr(2'd2, 8'h02);
    rd(2'd2, v); chk("R8 partial clear", int'(v), 8'h04);
    wr(2'd2, 8'h0F);
    load_dev(16'h00A5, 8, 1'b0);
    xfer(8'hFF, v); chk("R5 read 0xA5", int'(v), 8'hA5);
  endtask

  task automatic t_single_std;
    logic [7:0] v;
    load_dev('0, 0, 1'b0);
    wr(2'd1, 8'h02);
    xfer(8'h00, v);
    chk("R6 bit 0", int'(v), 0);
    chk_rng("R12 write0 low", last_low, 60 * D - D, 60 * D + 1);
    xfer(8'h01, v);
    chk("R6 bit 1", int'(v), 1);
    chk_rng("R12 write1 low", last_low, 6 * D - D, 6 * D + 1);
    xfer(8'hFE, v);
    chk("R6 only bit0 sent", int'(v), 0);
    chk("R6 one slot", last_falls, 1);
    load_dev(16'h0000, 1, 1'b0);
    xfer(8'h03, v);
    chk("R12 read sampled 0", int'(v), 0);
  endtask

  task automatic t_overdrive;
    logic [7:0] v;
    load_dev('0, 0, 1'b1);
    wr(2'd1, 8'h06);
    xfer(8'h00, v);
    chk("R4 od bit 0", int'(v), 0);
    chk_rng("R4 od write0 low", last_low, 8 * D - D, 8 * D + 1);
    xfer(8'h01, v);
    chk("R4 od bit 1", int'(v), 1);
    chk_rng("R4 od write1 low", last_low, 1, D + 1);
    load_dev(16'h0000, 1, 1'b1);
    xfer(8'h01, v);
    chk("R4 od read sampled 0", int'(v), 0);
    t_reset_pulse(1'b1, 1'b1, 70);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_search;
    logic [7:0] v;
    // slot responses a0 b0 w0 a1 b1 w1 ... LSB first
    load_dev(16'h09AC, 12, 1'b0);
    wr(2'd1, 8'h0A);
    xfer(8'h05, v);
    chk("R10 search result", int'(v), 8'h39);
    chk("R10 twelve slots", last_falls, 12);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_busy;
    logic [7:0] v;
    int f0;
    load_dev('0, 0, 1'b0);
    wr(2'd1, 8'h00);
    f0 = fall_cnt;
    wr(2'd0, 8'h55);
    repeat (20) @(negedge clk);
    rd(2'd1, v); chk("R11 busy seen", int'(v[6]), 1);
    wr(2'd0, 8'hAA);
    wr(2'd1, 8'h01);
    wait_flag(2);
    rd(2'd0, v); chk("R11 data write ignored", int'(v), 8'h55);
    chk("R11 no extra slots", fall_cnt - f0, 8);
    repeat (50) @(negedge clk);
    rd(2'd2, v); chk("R11 reset ignored", int'(v[0]), 0);
    wr(2'd2, 8'h0F);
  endtask

  task automatic t_short;
    logic [7:0] v;
    load_dev('0, 0, 1'b0);
    wr(2'd1, 8'h00);
    xfer(8'hFF, v);
    rd(2'd2, v); chk("R9 no short on idle bus", int'(v[3]), 0);
    stuck = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'hFF);
    wait_flag(2);
    rd(2'd2, v); chk("R9 short flag", int'(v[3]), 1);
    stuck = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h0F);
  endtask

  task automatic t_pullup;
    wr(2'd1, 8'h10);
    @(negedge clk); chk("R13 pullup on", int'(pu), 1);
    wr(2'd1, 8'h00);
    @(negedge clk); chk("R13 pullup off", int'(pu), 0);
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_div();
    t_reset_pulse(1'b0, 1'b1, 480);
    t_reset_pulse(1'b0, 1'b0, 480);
    t_byte();
    t_single_std();
    t_overdrive();
    t_search();
    t_busy();
    t_short();
    t_pullup();
    summary();
    $finish;
  end
endmodule